// File: doc/BRIEF.md
# TDM Frame Sync Generator

This block derives the frame, slot and bit timing of a time-division-multiplexed serial audio link. It runs on the serial bit clock: every rising edge advances one bit time. It drives the frame sync line and tells the serializers next to it where the link is: which slot is active, which bit of that slot is on the wire, when a slot begins, when a frame begins, and which bit time carries the first data bit of the frame. All outputs change just after a rising edge of the bit clock. The serializers launch data on the falling edge and capture it on the rising edge, so these outputs are stable at both edges.

Five configuration inputs set the timing:
- the number of slots, minus one;
- the slot size, as a 2-bit code;
- the frame sync width, which is one bit time, one full slot, or half the frame;
- an inversion of the frame sync polarity;
- a one-bit delay from frame start to the first data bit.

These inputs are sampled only on the edge that starts a frame. Software can therefore change them at any time, and no frame ever mixes two settings.

Top module: `tdm_fsync_gen`

## Requirements
- R1: While `rst_n` is low, `fs_o`, `slot_idx`, `bit_pos`, `frame_start`, `slot_start` and `data_first` are all 0. The first frame begins on the first rising clock edge after `rst_n` goes high, so `frame_start` is 1 in the cycle that follows that edge.
- R2: The slot size code sets the bits per slot: 0 gives 8, 1 gives 16, 2 gives 24 and 3 gives 32. `bit_pos` counts up from 0 to that size minus one within each slot, then returns to 0.
- R3: A frame holds `cfg_nslots` + 1 slots. `slot_idx` advances by one at each slot start, and after the last slot it wraps to 0.
- R4: `frame_start` is 1 for exactly the first bit time of each frame. At that point `slot_idx` and `bit_pos` are both 0.
- R5: `slot_start` is 1 exactly in the bit times where `bit_pos` is 0.
- R6: Width code 0 (bit) makes the frame sync active for only the first bit time of the frame. Code 3 is reserved and behaves the same as code 0.
- R7: Width code 1 (slot) makes the frame sync active for every bit time of slot 0.
- R8: Width code 2 (half) makes the frame sync active for the first floor(total/2) bit times of the frame, where total = (`cfg_nslots` + 1) × slot size.
- R9: `fs_o` equals the active level XOR `cfg_fsinv`. It is high when active if `cfg_fsinv` is 0, and low when active if `cfg_fsinv` is 1.
- R10: `data_first` is 1 for one bit time per frame. That bit time is frame bit 0 when `cfg_bdelay` is 0, and frame bit 1 when `cfg_bdelay` is 1.
- R11: The configuration inputs are latched only on the edge that starts a frame. A change made in the middle of a frame has no effect on that frame and takes effect from the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock; each rising edge is one bit time |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_nslots | input | SLOT_W | Slots per frame minus one |
| cfg_ssize | input | 2 | Slot size code (8/16/24/32 bits) |
| cfg_fsmode | input | 2 | Frame sync width: 0 bit, 1 slot, 2 half frame, 3 as 0 |
| cfg_fsinv | input | 1 | Invert frame sync polarity |
| cfg_bdelay | input | 1 | First data bit one bit time after frame start |
| fs_o | output | 1 | Frame sync line level |
| slot_idx | output | SLOT_W | Current slot number |
| bit_pos | output | 5 | Bit position within the current slot |
| frame_start | output | 1 | First bit time of a frame |
| slot_start | output | 1 | First bit time of a slot |
| data_first | output | 1 | Bit time of the first data bit of the frame |

## Verification
The bench builds the block with `SLOT_W` = 2. This allows up to four slots and keeps the longest frame at 128 bit times, which makes a full sweep practical. The sweep covers every combination of slot count, slot size code, sync width code (including the reserved code), polarity and bit delay, 256 settings in all. Each frame is compared bit time by bit time against counters kept in the bench. The next setting is applied halfway through each frame, so every frame also tests that a mid-frame change is ignored and that the slot index wraps into the following frame.

// File: rtl/tdm_pkg.sv
// Package: shared types and helpers for the TDM frame sync generator.
// Assumes slot size is coded on 2 bits as multiples of 8 bit times.
package tdm_pkg;

    typedef enum logic [1:0] {
        FSW_BIT  = 2'd0,
        FSW_SLOT = 2'd1,
        FSW_HALF = 2'd2,
        FSW_RSVD = 2'd3
    } fs_width_e;

    // Bits per slot for a size code: (code + 1) * 8.
    function automatic logic [5:0] slot_bits(input logic [1:0] code);
        return {1'b0, ({1'b0, code} + 3'd1), 2'b00} << 1;
    endfunction

endpackage

// File: rtl/tdm_cfg_hold.sv
// Module: tdm_cfg_hold
// Holds the active frame configuration. It reloads the settings from the
// configuration inputs only when load is high, which happens on the edge
// that starts a frame. It also precomputes the last bit index of a slot and
// the half-frame sync length, so the per-bit logic stays shallow.
// Assumes load is high for exactly one edge per frame.
module tdm_cfg_hold
    import tdm_pkg::*;
#(
    parameter int SLOT_W = 4,
    localparam int FBIT_W = SLOT_W + 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [SLOT_W-1:0] cfg_nslots,
    input  logic [1:0]        cfg_ssize,
    input  logic [1:0]        cfg_fsmode,
    input  logic              cfg_fsinv,
    input  logic              cfg_bdelay,
    output logic [SLOT_W-1:0] act_last_slot,
    output logic [4:0]        act_bits_m1,
    output fs_width_e         act_mode,
    output logic              act_inv,
    output logic              act_bdly,
    output logic [FBIT_W-1:0] act_half
);

    logic [5:0]        new_bits;
    logic [FBIT_W-1:0] new_total;

    // Derive slot length and total frame length from the incoming settings.
    always_comb begin
        new_bits  = slot_bits(cfg_ssize);
        new_total = (FBIT_W'(cfg_nslots) + FBIT_W'(1)) * FBIT_W'(new_bits);
    end

    // Capture the settings at a frame boundary only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_last_slot <= '0;
            act_bits_m1   <= '0;
            act_mode      <= FSW_BIT;
            act_inv       <= 1'b0;
            act_bdly      <= 1'b0;
            act_half      <= '0;
        end else if (load) begin
            act_last_slot <= cfg_nslots;
            act_bits_m1   <= 5'(new_bits - 6'd1);
            act_mode      <= fs_width_e'(cfg_fsmode);
            act_inv       <= cfg_fsinv;
            act_bdly      <= cfg_bdelay;
            act_half      <= new_total >> 1;
        end
    end

endmodule

// File: rtl/tdm_frame_cnt.sv
// Module: tdm_frame_cnt
// Keeps the bit-in-slot, slot and bit-in-frame counters. It raises load on
// the edge that starts a frame: the first edge after reset, or the edge
// after the last bit of the last slot.
// Assumes act_* hold the settings of the frame that is currently running.
module tdm_frame_cnt #(
    parameter int SLOT_W = 4,
    localparam int FBIT_W = SLOT_W + 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] act_last_slot,
    input  logic [4:0]        act_bits_m1,
    output logic              load,
    output logic              running,
    output logic [4:0]        bit_cnt,
    output logic [SLOT_W-1:0] slot_cnt,
    output logic [FBIT_W-1:0] fbit_cnt
);

    logic slot_end;

    // Detect the last bit of a slot and the end of the frame.
    always_comb begin
        slot_end = (bit_cnt == act_bits_m1);
        load     = !running || (slot_end && (slot_cnt == act_last_slot));
    end

    // Advance the counters by one bit time, or restart them for a new frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running  <= 1'b0;
            bit_cnt  <= '0;
            slot_cnt <= '0;
            fbit_cnt <= '0;
        end else if (load) begin
            running  <= 1'b1;
            bit_cnt  <= '0;
            slot_cnt <= '0;
            fbit_cnt <= '0;
        end else begin
            fbit_cnt <= fbit_cnt + FBIT_W'(1);
            if (slot_end) begin
                bit_cnt  <= '0;
                slot_cnt <= slot_cnt + SLOT_W'(1);
            end else begin
                bit_cnt  <= bit_cnt + 5'd1;
            end
        end
    end

endmodule

// File: rtl/tdm_fs_shape.sv
// Module: tdm_fs_shape
// Purely combinational. It forms the frame sync level and the slot, frame
// and first-data strobes from the counters and the active settings.
// Assumes the counters are 0 when running is low.
module tdm_fs_shape
    import tdm_pkg::*;
#(
    parameter int SLOT_W = 4,
    localparam int FBIT_W = SLOT_W + 6
) (
    input  logic              running,
    input  logic [4:0]        bit_cnt,
    input  logic [SLOT_W-1:0] slot_cnt,
    input  logic [FBIT_W-1:0] fbit_cnt,
    input  fs_width_e         act_mode,
    input  logic              act_inv,
    input  logic              act_bdly,
    input  logic [FBIT_W-1:0] act_half,
    output logic              fs_o,
    output logic              frame_start,
    output logic              slot_start,
    output logic              data_first
);

    logic fs_active;

    // Choose the frame sync active window from the width mode.
    always_comb begin
        unique case (act_mode)
            FSW_SLOT: fs_active = running && (slot_cnt == '0);
            FSW_HALF: fs_active = running && (fbit_cnt < act_half);
            default:  fs_active = running && (fbit_cnt == '0);
        endcase
    end

    // Apply polarity and derive the timing strobes.
    always_comb begin
        fs_o        = fs_active ^ act_inv;
        frame_start = running && (fbit_cnt == '0);
        slot_start  = running && (bit_cnt == '0);
        data_first  = running && (fbit_cnt == FBIT_W'(act_bdly));
    end

endmodule

// File: rtl/tdm_fsync_gen.sv
// Module: tdm_fsync_gen (top)
// TDM frame timing generator that runs on the serial bit clock. Every
// output changes only after a rising edge, so the serializers can drive
// data on the falling edge and capture it on the rising edge.
// Assumes a synchronous active-low reset in the bit clock domain.
module tdm_fsync_gen
    import tdm_pkg::*;
#(
    parameter int SLOT_W = 4,
    localparam int FBIT_W = SLOT_W + 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] cfg_nslots,
    input  logic [1:0]        cfg_ssize,
    input  logic [1:0]        cfg_fsmode,
    input  logic              cfg_fsinv,
    input  logic              cfg_bdelay,
    output logic              fs_o,
    output logic [SLOT_W-1:0] slot_idx,
    output logic [4:0]        bit_pos,
    output logic              frame_start,
    output logic              slot_start,
    output logic              data_first
);

    logic              load;
    logic              running;
    logic [SLOT_W-1:0] act_last_slot;
    logic [4:0]        act_bits_m1;
    fs_width_e         act_mode;
    logic              act_inv;
    logic              act_bdly;
    logic [FBIT_W-1:0] act_half;
    logic [FBIT_W-1:0] fbit_cnt;

    tdm_cfg_hold #(.SLOT_W(SLOT_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .load(load),
        .cfg_nslots(cfg_nslots), .cfg_ssize(cfg_ssize),
        .cfg_fsmode(cfg_fsmode), .cfg_fsinv(cfg_fsinv),
        .cfg_bdelay(cfg_bdelay),
        .act_last_slot(act_last_slot), .act_bits_m1(act_bits_m1),
        .act_mode(act_mode), .act_inv(act_inv),
        .act_bdly(act_bdly), .act_half(act_half)
    );

    tdm_frame_cnt #(.SLOT_W(SLOT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .act_last_slot(act_last_slot), .act_bits_m1(act_bits_m1),
        .load(load), .running(running),
        .bit_cnt(bit_pos), .slot_cnt(slot_idx), .fbit_cnt(fbit_cnt)
    );

    tdm_fs_shape #(.SLOT_W(SLOT_W)) u_fs (
        .running(running), .bit_cnt(bit_pos), .slot_cnt(slot_idx),
        .fbit_cnt(fbit_cnt), .act_mode(act_mode), .act_inv(act_inv),
        .act_bdly(act_bdly), .act_half(act_half),
        .fs_o(fs_o), .frame_start(frame_start),
        .slot_start(slot_start), .data_first(data_first)
    );

endmodule

// File: rtl/tdm_fsync_chk.sv
// Module: tdm_fsync_chk
// Assertion checker bound to tdm_fsync_gen. It checks the sequencing of the
// counters and strobes, and that the active settings hold within a frame.
module tdm_fsync_chk #(
    parameter int SLOT_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_start,
    input logic              slot_start,
    input logic              data_first,
    input logic [SLOT_W-1:0] slot_idx,
    input logic [4:0]        bit_pos,
    input logic [SLOT_W-1:0] act_last_slot
);

    logic seen;

    // Mark that a first frame has begun, so $past refers to running state.
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= 1'b0;
        else if (frame_start) seen <= 1'b1;
    end

    a_r2_bit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !slot_start) |-> (bit_pos == $past(bit_pos) + 5'd1));

    a_r3_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && slot_start && !frame_start)
            |-> (slot_idx == $past(slot_idx) + SLOT_W'(1)));

    a_r4_frame_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

    a_r4_frame_origin: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (slot_idx == '0 && bit_pos == 5'd0 && slot_start));

    a_r10_first_in_slot0: assert property (@(posedge clk) disable iff (!rst_n)
        data_first |-> (slot_idx == '0 && bit_pos <= 5'd1));

    a_r11_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !frame_start) |-> $stable(act_last_slot));

endmodule

bind tdm_fsync_gen tdm_fsync_chk #(.SLOT_W(SLOT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .slot_start(slot_start), .data_first(data_first),
    .slot_idx(slot_idx), .bit_pos(bit_pos), .act_last_slot(act_last_slot)
);

// File: tb/sim_tdm_fsync_gen.sv
`timescale 1ns/1ps
module sim_tdm_fsync_gen;

    localparam int SW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [SW-1:0] cfg_nslots = '0;
    logic [1:0]    cfg_ssize = '0;
    logic [1:0]    cfg_fsmode = '0;
    logic          cfg_fsinv = 1'b0;
    logic          cfg_bdelay = 1'b0;
    logic          fs_o, frame_start, slot_start, data_first;
    logic [SW-1:0] slot_idx;
    logic [4:0]    bit_pos;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tdm_fsync_gen #(.SLOT_W(SW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_nslots(cfg_nslots),
        .cfg_ssize(cfg_ssize), .cfg_fsmode(cfg_fsmode),
        .cfg_fsinv(cfg_fsinv), .cfg_bdelay(cfg_bdelay),
        .fs_o(fs_o), .slot_idx(slot_idx), .bit_pos(bit_pos),
        .frame_start(frame_start), .slot_start(slot_start),
        .data_first(data_first)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply_cfg(input int idx);
        cfg_nslots = SW'(idx & 3);
        cfg_ssize  = 2'((idx >> 2) & 3);
        cfg_fsmode = 2'((idx >> 4) & 3);
        cfg_fsinv  = 1'((idx >> 6) & 1);
        cfg_bdelay = 1'((idx >> 7) & 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        apply_cfg(0);
        repeat (3) @(negedge clk);
        // R1: idle outputs while held in reset
        chk("R1 fs_o in reset", int'(fs_o), 0);
        chk("R1 slot_idx in reset", int'(slot_idx), 0);
        chk("R1 bit_pos in reset", int'(bit_pos), 0);
        chk("R1 strobes in reset",
            int'(frame_start) + int'(slot_start) + int'(data_first), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 first frame after release", int'(frame_start), 1);

        for (int idx = 0; idx < 256; idx++) begin
            int ns, bits, total, half, md, inv, bd, wait_n;
            ns   = idx & 3;
            bits = (((idx >> 2) & 3) + 1) * 8;
            md   = (idx >> 4) & 3;
            inv  = (idx >> 6) & 1;
            bd   = (idx >> 7) & 1;
            total = (ns + 1) * bits;
            half  = total / 2;
            wait_n = 0;
            while (!frame_start && wait_n < 300) begin
                @(negedge clk);
                wait_n++;
            end
            chk("R4 frame start reached", int'(frame_start), 1);
            for (int k = 0; k < total; k++) begin
                int act_lvl;
                string fsr;
                case (md)
                    1: begin act_lvl = (k < bits) ? 1 : 0; fsr = "R7 fs slot width"; end
                    2: begin act_lvl = (k < half) ? 1 : 0; fsr = "R8 fs half frame"; end
                    default: begin act_lvl = (k == 0) ? 1 : 0; fsr = "R6 fs bit width"; end
                endcase
                if (inv == 1) fsr = {fsr, " R9 inverted"};
                chk(fsr, int'(fs_o), act_lvl ^ inv);
                chk("R2 bit_pos", int'(bit_pos), k % bits);
                chk("R3 slot_idx", int'(slot_idx), k / bits);
                chk("R4 frame_start", int'(frame_start), (k == 0) ? 1 : 0);
                chk("R5 slot_start", int'(slot_start), (k % bits == 0) ? 1 : 0);
                chk("R10 data_first", int'(data_first), (k == bd) ? 1 : 0);
                if (k == total - 1)
                    chk("R11 frame kept length after mid-frame change",
                        int'(bit_pos), bits - 1);
                // R11: next setting arrives mid-frame, must wait for next frame
                if (k == half) apply_cfg((idx + 1) % 256);
                @(negedge clk);
            end
            // R3: slot index wrapped at the frame boundary
            chk("R3 wrap to slot 0", int'(slot_idx), 0);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule